// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block paces one successive-approximation conversion by counting ADC clock periods. The ADC clock is not used directly. A prescaler outside the block supplies two single-cycle strobes on the system clock: one marks each rising edge of the ADC clock and the other marks each falling edge. The sequencer works out whether the next conversion is short or long. It sends out a sample-and-hold pulse at the point in the conversion that matches the conversion type. At the end of the conversion it captures the converter's result into a high/low register pair and raises a completion flag.

There are three ways to start a conversion: a software start request, a trigger edge in trigger mode, or the automatic restart in free-running mode. The analog comparator is not part of this block. It appears only as a result bus that the sequencer samples at completion.

Top module: `adc_seq_top`

## Requirements
- R1: Reset clears busy, completion flag, sample strobe and both result registers. A start request made while enabled and idle sets busy on the next cycle. The conversion then begins on the first ADC rising-edge strobe that comes strictly after the request cycle.
- R2: A normal conversion completes on the 13th rising-edge strobe after its start strobe.
- R3: The first conversion after reset, or after enable is lowered and raised again, completes on the 25th rising-edge strobe after its start strobe.
- R4: In a normal software-started or free-running conversion, the sample strobe is a one-cycle pulse. It follows the first falling-edge strobe after the first rising edge of the conversion. In a long conversion it follows the falling-edge strobe after the 13th rising edge.
- R5: In trigger mode (mode code 2'b10), a normal conversion raises the sample strobe one cycle after the 2nd rising-edge strobe that follows the start strobe.
- R6: On the cycle after the completing strobe, the result registers hold the value present on the result bus during that strobe. The high register holds bits [9:8] and the low register holds bits [7:0]. The completion flag is set in the same cycle.
- R7: In single mode (mode 2'b00) and in trigger mode, busy clears in the same cycle that the completion flag is set.
- R8: In free-running mode (mode 2'b01), busy stays high at completion. The completing strobe is also the start strobe of the next conversion, which runs 13 strobes whatever the state of the flag.
- R9: In trigger mode with differential select high, every conversion completes on the 25th rising-edge strobe after its start.
- R10: A flag-clear pulse clears the completion flag on the next cycle. A completion in the same cycle wins, and the flag stays set.
- R11: Lowering enable drops busy on the next cycle and discards the conversion. The flag and the result registers keep their values, and the next conversion is a 25-strobe one.
- R12: Start requests and trigger edges are ignored while busy or while disabled. Trigger edges are also ignored outside trigger mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable; low aborts and re-arms the long first conversion |
| startReq | input | 1 | One-cycle software start request |
| trigEdge | input | 1 | One-cycle detected trigger edge |
| mode | input | 2 | 00 single, 01 free-running, 10 trigger, 11 treated as single |
| diffSel | input | 1 | Differential input selected |
| adcTick | input | 1 | Strobe marking an ADC clock rising edge |
| adcHalf | input | 1 | Strobe marking an ADC clock falling edge |
| doneClr | input | 1 | One-cycle completion flag clear |
| convData | input | 10 | Result from the converter model |
| sampleStb | output | 1 | One-cycle sample-and-hold pulse |
| busy | output | 1 | Conversion requested or in progress |
| doneFlag | output | 1 | Completion flag |
| resHi | output | 2 | Most significant result bits |
| resLo | output | 8 | Least significant result bits |

## Verification
The bench measures conversion lengths in rising-edge strobes. These measurements catch several faults:
- A first-conversion flag that is never re-armed after enable drops would give 13 instead of 25.
- A start taken on the same strobe as the request would be one strobe short.
- A trigger-mode sample point that shares the software half-cycle decode would pulse one strobe early.

In free-running runs the flag is cleared on many cycles, including the completing one. A design that let the clear win, or that dropped busy at completion, would diverge from the reference model on that cycle. Aborts, and requests made while busy or disabled, are checked against the result registers and the flag. A design that restarted or overwrote the results would show a changed value.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_FREE   = 2'b01,
    MODE_TRIG   = 2'b10,
    MODE_RSVD   = 2'b11
  } convMode_e;

  // Strobes passed from control to datapath, one cycle wide
  typedef struct packed {
    logic capture;    // conversion finished this cycle
    logic sampleNow;  // sample-and-hold point reached this cycle
  } seqStb_t;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NORM_LEN  = 13,
  parameter int LONG_LEN  = 25,
  parameter int NORM_SAMP = 1,
  parameter int LONG_SAMP = 13,
  parameter int TRIG_SAMP = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       startReq,
  input  logic       trigEdge,
  input  logic [1:0] mode,
  input  logic       diffSel,
  input  logic       adcTick,
  input  logic       adcHalf,
  output logic       busy,
  output seqStb_t    stb
);

  localparam int CNT_W = $clog2(LONG_LEN + 1);
  localparam logic [CNT_W-1:0] NORM_LAST  = CNT_W'(NORM_LEN - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_LEN - 1);
  localparam logic [CNT_W-1:0] NORM_SPT   = CNT_W'(NORM_SAMP);
  localparam logic [CNT_W-1:0] LONG_SPT   = CNT_W'(LONG_SAMP);
  localparam logic [CNT_W-1:0] TRIG_SPT   = CNT_W'(TRIG_SAMP - 1);

  logic busyQ, pendQ, runQ, firstQ, longQ, trigQ;
  logic [CNT_W-1:0] cntQ;

  logic isTrigMode, isFreeMode;
  logic launch, startNow, lastCycle, complete;

  assign isTrigMode = (mode == MODE_TRIG);
  assign isFreeMode = (mode == MODE_FREE);

  assign launch    = enable && !busyQ && (startReq || (trigEdge && isTrigMode));
  assign startNow  = enable && pendQ && adcTick;
  assign lastCycle = longQ ? (cntQ == LONG_LAST) : (cntQ == NORM_LAST);
  assign complete  = enable && runQ && adcTick && lastCycle;

  always_comb begin
    stb.capture   = complete;
    stb.sampleNow = 1'b0;
    if (enable && runQ) begin
      if (longQ)      stb.sampleNow = adcHalf && (cntQ == LONG_SPT);
      else if (trigQ) stb.sampleNow = adcTick && (cntQ == TRIG_SPT);
      else            stb.sampleNow = adcHalf && (cntQ == NORM_SPT);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      pendQ  <= 1'b0;
      runQ   <= 1'b0;
      firstQ <= 1'b1;
      longQ  <= 1'b0;
      trigQ  <= 1'b0;
      cntQ   <= '0;
    end else if (!enable) begin
      busyQ  <= 1'b0;
      pendQ  <= 1'b0;
      runQ   <= 1'b0;
      firstQ <= 1'b1;
      cntQ   <= '0;
    end else begin
      if (launch) begin
        busyQ <= 1'b1;
        pendQ <= 1'b1;
      end
      if (startNow) begin
        runQ  <= 1'b1;
        pendQ <= 1'b0;
        cntQ  <= '0;
        longQ <= firstQ || (diffSel && isTrigMode);
        trigQ <= isTrigMode;
      end else if (runQ && adcTick) begin
        if (complete) begin
          firstQ <= 1'b0;
          cntQ   <= '0;
          if (isFreeMode) begin
            longQ <= 1'b0;
            trigQ <= 1'b0;
          end else begin
            runQ  <= 1'b0;
            busyQ <= 1'b0;
          end
        end else begin
          cntQ <= cntQ + 1'b1;
        end
      end
    end
  end

  assign busy = busyQ;

endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int LO_W  = 8,
  localparam int HI_W = RES_W - LO_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStb_t          stb,
  input  logic             doneClr,
  input  logic [RES_W-1:0] convData,
  output logic             sampleStb,
  output logic             doneFlag,
  output logic [HI_W-1:0]  resHi,
  output logic [LO_W-1:0]  resLo
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleStb <= 1'b0;
      doneFlag  <= 1'b0;
      resHi     <= '0;
      resLo     <= '0;
    end else begin
      sampleStb <= stb.sampleNow;
      if (stb.capture) begin
        resHi    <= convData[RES_W-1:LO_W];
        resLo    <= convData[LO_W-1:0];
        doneFlag <= 1'b1;
      end else if (doneClr) begin
        doneFlag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int LO_W  = 8,
  localparam int HI_W = RES_W - LO_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             startReq,
  input  logic             trigEdge,
  input  logic [1:0]       mode,
  input  logic             diffSel,
  input  logic             adcTick,
  input  logic             adcHalf,
  input  logic             doneClr,
  input  logic [RES_W-1:0] convData,
  output logic             sampleStb,
  output logic             busy,
  output logic             doneFlag,
  output logic [HI_W-1:0]  resHi,
  output logic [LO_W-1:0]  resLo
);

  seqStb_t stb;

  adc_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .startReq (startReq),
    .trigEdge (trigEdge),
    .mode     (mode),
    .diffSel  (diffSel),
    .adcTick  (adcTick),
    .adcHalf  (adcHalf),
    .busy     (busy),
    .stb      (stb)
  );

  adc_seq_dp #(.RES_W(RES_W), .LO_W(LO_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .doneClr   (doneClr),
    .convData  (convData),
    .sampleStb (sampleStb),
    .doneFlag  (doneFlag),
    .resHi     (resHi),
    .resLo     (resLo)
  );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int RES_W = 10,
  parameter int LO_W  = 8,
  localparam int HI_W = RES_W - LO_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             startReq,
  input logic [1:0]       mode,
  input logic [RES_W-1:0] convData,
  input logic             sampleStb,
  input logic             busy,
  input logic             doneFlag,
  input logic [HI_W-1:0]  resHi,
  input logic [LO_W-1:0]  resLo
);

  // R1
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && enable && !busy) |=> busy);

  // R4
  sample_in_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> busy);

  // R6
  result_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> ({resHi, resLo} == $past(convData)));

  // R7
  single_clears_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(doneFlag) && ($past(mode) == 2'b00)) |-> !busy);

  // R8
  free_keeps_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == 2'b01) && busy && enable) |=> busy);

  // R11
  disable_drops_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !busy);

endmodule

bind adc_seq_top adc_seq_chk #(.RES_W(RES_W), .LO_W(LO_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .startReq  (startReq),
  .mode      (mode),
  .convData  (convData),
  .sampleStb (sampleStb),
  .busy      (busy),
  .doneFlag  (doneFlag),
  .resHi     (resHi),
  .resLo     (resLo)
);

// File: tb/sim_adc_seq_top.sv
`timescale 1ns/1ps
module sim_adc_seq_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0, startReq = 1'b0, trigEdge = 1'b0, diffSel = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       adcTick = 1'b0, adcHalf = 1'b0, doneClr = 1'b0;
  logic [9:0] convData = '0;
  logic       sampleStb, busy, doneFlag;
  logic [1:0] resHi;
  logic [7:0] resLo;

  always #5 clk = ~clk;

  adc_seq_top u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .startReq(startReq),
    .trigEdge(trigEdge), .mode(mode), .diffSel(diffSel), .adcTick(adcTick),
    .adcHalf(adcHalf), .doneClr(doneClr), .convData(convData),
    .sampleStb(sampleStb), .busy(busy), .doneFlag(doneFlag),
    .resHi(resHi), .resLo(resLo)
  );

  int checks = 0, fails = 0;
  string curTag = "R1";
  bit finished = 0;

  // stimulus requests
  bit reqRst = 1, reqEn = 0, reqStart = 0, reqTrig = 0, reqClr = 0, reqDiff = 0;
  int reqMode = 0;
  bit autoClr = 0;
  int phase = 0, tickSeen = 0, dataSeq = 5, lastTickData = 0, cyc = 0;

  // reference model state
  int mBusy, mPend, mRun, mFirst, mLong, mTrg, mCnt, mSamp, mDone, mHi, mLo;

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mBusy = 0; mPend = 0; mRun = 0; mFirst = 1; mLong = 0; mTrg = 0;
    mCnt = 0; mSamp = 0; mDone = 0; mHi = 0; mLo = 0;
  endtask

  task automatic modelStep();
    int last;
    bit comp, samp, launch, en, tk, hf;
    en = enable; tk = adcTick; hf = adcHalf;
    if (!rstN) begin
      modelReset();
      return;
    end
    last = mLong ? 24 : 12;
    comp = en && mRun && tk && (mCnt == last);
    samp = 0;
    if (en && mRun) begin
      if (mLong)     samp = hf && (mCnt == 13);
      else if (mTrg) samp = tk && (mCnt == 1);
      else           samp = hf && (mCnt == 1);
    end
    if (!en) begin
      mBusy = 0; mPend = 0; mRun = 0; mCnt = 0; mFirst = 1;
    end else begin
      launch = !mBusy && (startReq || (trigEdge && mode == 2));
      if (mPend && tk) begin
        mRun = 1; mPend = 0; mCnt = 0;
        mLong = (mFirst || (diffSel && mode == 2)) ? 1 : 0;
        mTrg = (mode == 2) ? 1 : 0;
      end else if (mRun && tk) begin
        if (comp) begin
          mFirst = 0; mCnt = 0;
          if (mode == 1) begin mLong = 0; mTrg = 0; end
          else begin mRun = 0; mBusy = 0; end
        end else mCnt++;
      end
      if (launch) begin mBusy = 1; mPend = 1; end
    end
    mSamp = samp;
    if (comp) begin
      mHi = convData / 256; mLo = convData % 256; mDone = 1;
    end else if (doneClr) mDone = 0;
  endtask

  // one system clock: compare, drive, advance model
  task automatic step();
    @(negedge clk);
    cyc++;
    check(curTag, "busy", busy, mBusy);
    check(curTag, "doneFlag", doneFlag, mDone);
    check(curTag, "sampleStb", sampleStb, mSamp);
    check(curTag, "resHi", resHi, mHi);
    check(curTag, "resLo", resLo, mLo);
    phase = (phase + 1) % 4;
    rstN     = !reqRst;
    enable   = reqEn;
    mode     = 2'(reqMode);
    diffSel  = reqDiff;
    adcTick  = (phase == 0);
    adcHalf  = (phase == 2);
    startReq = reqStart; reqStart = 0;
    trigEdge = reqTrig;  reqTrig = 0;
    doneClr  = reqClr || (autoClr && (cyc % 5 == 0)); reqClr = 0;
    dataSeq  = (dataSeq * 13 + 7) % 1024;
    convData = 10'(dataSeq);
    if (adcTick) begin tickSeen++; lastTickData = dataSeq; end
    modelStep();
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // ticks elapsed from t0 until the chosen output is seen high
  task automatic waitFor(int sel, int t0, output int elapsed);
    int guard = 0;
    do begin
      step();
      guard++;
    end while (((sel == 0) ? doneFlag : sampleStb) == 1'b0 && guard < 400);
    elapsed = tickSeen - t0;
  endtask

  task automatic clearFlag();
    reqClr = 1; step();
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    int t0, el, keepHi, keepLo;
    modelReset();
    steps(3);
    reqRst = 0; steps(2);
    curTag = "R1";
    check("R1", "reset busy", busy, 0);
    check("R1", "reset flag", doneFlag, 0);
    check("R1", "reset result", {resHi, resLo}, 0);

    // first conversion after enable
    curTag = "R3"; reqEn = 1; steps(3);
    reqStart = 1; step(); t0 = tickSeen;
    waitFor(0, t0, el);
    check("R3", "first conv ticks", el, 26);
    check("R7", "busy after single", busy, 0);
    check("R6", "captured result", {resHi, resLo}, lastTickData);

    // normal conversion, sample point
    curTag = "R10"; clearFlag(); step();
    check("R10", "flag cleared", doneFlag, 0);
    curTag = "R4"; reqStart = 1; step(); t0 = tickSeen;
    waitFor(1, t0, el);
    check("R4", "normal sample ticks", el, 2);
    curTag = "R2"; waitFor(0, t0, el);
    check("R2", "normal conv ticks", el, 14);

    // start while busy is ignored
    curTag = "R12"; clearFlag();
    reqStart = 1; step(); t0 = tickSeen;
    steps(10); reqStart = 1; step();
    waitFor(0, t0, el);
    check("R12", "restart while busy ignored", el, 14);

    // disabled start ignored; trigger outside trigger mode ignored
    clearFlag(); reqEn = 0; step(); reqStart = 1; steps(20);
    check("R12", "start while disabled", busy, 0);
    reqEn = 1; steps(2); reqTrig = 1; steps(20);
    check("R12", "trigger in single mode", busy, 0);

    // abort by disable
    curTag = "R11"; reqStart = 1; step(); t0 = tickSeen;
    waitFor(0, t0, el);
    check("R3", "first conv after re-enable", el, 26);
    clearFlag(); keepHi = resHi; keepLo = resLo;
    reqStart = 1; steps(30); reqEn = 0; steps(3);
    check("R11", "busy after abort", busy, 0);
    check("R11", "flag unchanged", doneFlag, 0);
    check("R11", "result unchanged", {resHi, resLo}, keepHi * 256 + keepLo);
    reqEn = 1; steps(2); reqStart = 1; step(); t0 = tickSeen;
    waitFor(0, t0, el);
    check("R11", "long conv after abort", el, 26);

    // free-running
    curTag = "R8"; clearFlag(); reqMode = 1;
    reqStart = 1; step(); t0 = tickSeen;
    waitFor(0, t0, el);
    check("R8", "free first ticks", el, 14);
    for (int k = 0; k < 2; k++) begin
      t0 = tickSeen; clearFlag();
      waitFor(0, t0, el);
      check("R8", "free period ticks", el, 13);
      check("R8", "busy held", busy, 1);
    end
    curTag = "R10"; autoClr = 1; steps(300); autoClr = 0;
    curTag = "R7"; clearFlag(); reqMode = 0; t0 = tickSeen;
    waitFor(0, t0, el);
    check("R7", "busy after free stop", busy, 0);

    // trigger mode
    curTag = "R5"; clearFlag(); reqMode = 2; steps(2);
    reqTrig = 1; step(); t0 = tickSeen;
    waitFor(1, t0, el);
    check("R5", "trigger sample ticks", el, 3);
    waitFor(0, t0, el);
    check("R5", "trigger conv ticks", el, 14);
    check("R7", "busy after trigger conv", busy, 0);

    // differential trigger: always long
    curTag = "R9"; reqDiff = 1;
    for (int k = 0; k < 2; k++) begin
      clearFlag(); reqTrig = 1; step(); t0 = tickSeen;
      waitFor(0, t0, el);
      check("R9", "diff trigger conv ticks", el, 26);
    end
    reqDiff = 0; steps(10);
    finishRun();
  end

endmodule